// File: doc/BRIEF.md
# I2C Slave Address Matcher

This block watches an already synchronised SCL/SDA pair and tracks the address phase of every I2C transfer. After a START it shifts in the first byte, MSB first, on SCL rising edges. By the eighth rising edge it has decided whether this slave should acknowledge. In 10-bit mode it does the same for the second address byte. The decision is built from a programmable own address, a per-bit don't-care mask, a general-call enable and a 7-bit/10-bit mode select. Reserved addresses are refused before the mask or the own address is looked at.

The acknowledge request `ack_o` tells the pad logic to pull SDA low for the ninth clock. When an acknowledge is committed, `hit_o` and `gcall_o` pulse for one system clock and `rw_o` latches the direction bit. Once the address phase is over the block ignores the bus until the next START or STOP. Pad drivers, clock stretching, data bytes and clock generation belong to the neighbouring logic.

Top module: `i2c_addr_match`

## Requirements
- R1: After reset, `ack_o`, `hit_o`, `gcall_o` and `rw_o` are all 0.
- R2: In 7-bit mode, a first byte is eight bits: address bits 6..0 (MSB first) followed by the R/W bit. For a non-reserved address, the byte is acknowledged exactly when every address bit whose `cfg_mask[i]` is 0 equals `cfg_own_addr[i]`, for i from 0 to 6. `ack_o` rises at the commit, before the eighth SCL falling edge. `hit_o` pulses once for each acknowledged byte.
- R3: Address 0000000 with R/W=0 is acknowledged, in either mode, exactly when `cfg_gc_en` is 1. `gcall_o` pulses together with `hit_o` only for that byte.
- R4: In 7-bit mode, no address whose top four bits are 0000 or 1111 is acknowledged, apart from the general call under R3, whatever the mask. In 10-bit mode, a first byte is acknowledged only if it is the general call or has the form 11110 b9 b8 R/W.
- R5: In 10-bit mode, a first byte 11110 b9 b8 0 is acknowledged when b9..b8 equal `cfg_own_addr[9:8]`, with mask bits 9..8 as don't-care. The following byte is then acknowledged when its bits 7..0 equal `cfg_own_addr[7:0]`, with mask bits 7..0 as don't-care.
- R6: In 10-bit mode, a first byte 11110 b9 b8 1 whose b9..b8 match is acknowledged only if a complete 10-bit address has been acknowledged since the last STOP. A repeated START keeps that selection.
- R7: `rw_o` changes only when `hit_o` pulses. It then takes the R/W bit of an acknowledged first byte, or 0 on an acknowledged second byte.
- R8: A STOP or a START in the middle of a byte abandons that byte: it is never acknowledged and bit counting restarts. A START always begins a new first byte.
- R9: `ack_o` falls on the SCL falling edge that ends the ninth clock. It stays 0 for bytes that are not acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Synchronised SCL level |
| sda_i | input | 1 | Synchronised SDA level |
| cfg_own_addr | input | 10 | Own address; bits 6..0 used in 7-bit mode |
| cfg_mask | input | 10 | Don't-care mask, 1 = bit ignored |
| cfg_gc_en | input | 1 | Accept general call |
| cfg_ten_bit | input | 1 | 1 = 10-bit addressing |
| ack_o | output | 1 | Request to drive ACK during the ninth clock |
| hit_o | output | 1 | One-clock pulse when an acknowledge is committed |
| gcall_o | output | 1 | One-clock pulse for an acknowledged general call |
| rw_o | output | 1 | Latched direction bit of the last acknowledged byte |

## Verification
The bench builds the block with its default parameters, so both the mask path and the 10-bit path are present. With an 8-bit address byte, every first-byte value can be driven. All 256 first bytes are swept under three 7-bit settings: a plain address, a single don't-care bit with the general call disabled, and a fully masked address that only the reserved rules can refuse. All 256 first bytes are also swept in 10-bit mode, and all 256 second bytes are swept behind a matching header. Directed transfers cover repeated-START reads, aborted bytes and header bits masked as don't-care.

// File: rtl/i2c_am_pkg.sv
package i2c_am_pkg;

   localparam int FRAME_BITS = 8;
   localparam int ADDR_W     = 10;
   localparam logic [4:0] HDR10 = 5'b11110;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_FIRST,
      ST_SECOND,
      ST_HOLD
   } am_state_t;

   function automatic logic rsv7(input logic [6:0] a);
      return (a[6:3] == 4'b0000) || (a[6:3] == 4'b1111);
   endfunction

endpackage

// File: rtl/i2c_am_cond.sv
module i2c_am_cond (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);

   logic scl_q, sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_i;
         sda_q <= sda_i;
      end
   end

   assign scl_rise  = scl_i & ~scl_q;
   assign scl_fall  = ~scl_i & scl_q;
   assign start_det = scl_i & scl_q & sda_q & ~sda_i;
   assign stop_det  = scl_i & scl_q & ~sda_q & sda_i;

endmodule

// File: rtl/i2c_am_shifter.sv
module i2c_am_shifter #(
   parameter int BITS = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            clear,
   input  logic            shift_en,
   input  logic            sda_i,
   output logic            byte_full,
   output logic [BITS-1:0] byte_val,
   output logic            ninth_high
);

   localparam int CW = $clog2(BITS + 2);

   generate
      if (BITS < 3) begin : g_bad_bits
         $error("i2c_am_shifter: BITS must be at least 3");
      end
   endgenerate

   logic [CW-1:0]   cnt;
   logic [BITS-2:0] sr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         sr  <= '0;
      end else if (clear) begin
         cnt <= '0;
      end else if (shift_en && cnt <= CW'(BITS)) begin
         cnt <= cnt + 1'b1;
         if (cnt < CW'(BITS - 1))
            sr <= {sr[BITS-3:0], sda_i};
      end
   end

   assign byte_full  = shift_en && (cnt == CW'(BITS - 1));
   assign byte_val   = {sr, sda_i};
   assign ninth_high = (cnt == CW'(BITS + 1));

endmodule

// File: rtl/i2c_am_judge.sv
module i2c_am_judge
   import i2c_am_pkg::*;
#(
   parameter bit TEN_BIT_SUPPORT = 1'b1,
   parameter bit MASK_EN         = 1'b1
) (
   input  logic [FRAME_BITS-1:0] byte_i,
   input  logic                  second_i,
   input  logic [ADDR_W-1:0]     own_i,
   input  logic [ADDR_W-1:0]     mask_i,
   input  logic                  gc_en_i,
   input  logic                  ten_bit_i,
   input  logic                  ten_sel_i,
   output logic                  ack,
   output logic                  gc,
   output logic                  rw,
   output logic                  more
);

   logic [ADDR_W-1:0] mk;
   logic              ten_mode;

   generate
      if (MASK_EN) begin : g_mask
         assign mk = mask_i;
      end else begin : g_nomask
         assign mk = '0;
      end
      if (TEN_BIT_SUPPORT) begin : g_ten
         assign ten_mode = ten_bit_i;
      end else begin : g_seven
         assign ten_mode = 1'b0;
      end
   endgenerate

   logic [6:0] addr7;
   logic       r_bit, is_gc, hdr_ok, m7, m10hi, m10lo;

   assign addr7  = byte_i[7:1];
   assign r_bit  = byte_i[0];
   assign is_gc  = (addr7 == 7'd0) && !r_bit;
   assign hdr_ok = (addr7[6:2] == HDR10);
   assign m7     = ((addr7 ^ own_i[6:0]) & ~mk[6:0]) == 7'd0;
   assign m10hi  = ((addr7[1:0] ^ own_i[9:8]) & ~mk[9:8]) == 2'd0;
   assign m10lo  = ((byte_i ^ own_i[7:0]) & ~mk[7:0]) == 8'd0;

   always_comb begin
      ack  = 1'b0;
      gc   = 1'b0;
      more = 1'b0;
      rw   = r_bit;
      if (second_i) begin
         ack = m10lo;
         rw  = 1'b0;
      end else if (is_gc) begin
         ack = gc_en_i;
         gc  = gc_en_i;
      end else if (ten_mode) begin
         if (hdr_ok && m10hi) begin
            if (r_bit) begin
               ack = ten_sel_i;
            end else begin
               ack  = 1'b1;
               more = 1'b1;
            end
         end
      end else if (!rsv7(addr7)) begin
         ack = m7;
      end
   end

endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match
   import i2c_am_pkg::*;
#(
   parameter bit TEN_BIT_SUPPORT = 1'b1,
   parameter bit MASK_EN         = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   input  logic [ADDR_W-1:0] cfg_own_addr,
   input  logic [ADDR_W-1:0] cfg_mask,
   input  logic              cfg_gc_en,
   input  logic              cfg_ten_bit,
   output logic              ack_o,
   output logic              hit_o,
   output logic              gcall_o,
   output logic              rw_o
);

   logic scl_rise, scl_fall, start_det, stop_det;
   logic byte_full, ninth_high, ack_end, shift_en, sh_clear;
   logic [FRAME_BITS-1:0] byte_val;
   logic j_ack, j_gc, j_rw, j_more;

   am_state_t state;
   logic ack_q, hit_q, gc_q, rw_q, more_q, ten_sel_q;

   i2c_am_cond u_cond (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
      .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_det(start_det), .stop_det(stop_det)
   );

   assign shift_en = scl_rise && (state == ST_FIRST || state == ST_SECOND);
   assign ack_end  = scl_fall && ninth_high &&
                     (state == ST_FIRST || state == ST_SECOND);
   assign sh_clear = start_det | stop_det | ack_end;

   i2c_am_shifter #(.BITS(FRAME_BITS)) u_shift (
      .clk(clk), .rst_n(rst_n), .clear(sh_clear), .shift_en(shift_en),
      .sda_i(sda_i), .byte_full(byte_full), .byte_val(byte_val),
      .ninth_high(ninth_high)
   );

   i2c_am_judge #(
      .TEN_BIT_SUPPORT(TEN_BIT_SUPPORT),
      .MASK_EN(MASK_EN)
   ) u_judge (
      .byte_i(byte_val), .second_i(state == ST_SECOND),
      .own_i(cfg_own_addr), .mask_i(cfg_mask), .gc_en_i(cfg_gc_en),
      .ten_bit_i(cfg_ten_bit), .ten_sel_i(ten_sel_q),
      .ack(j_ack), .gc(j_gc), .rw(j_rw), .more(j_more)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         ack_q     <= 1'b0;
         hit_q     <= 1'b0;
         gc_q      <= 1'b0;
         rw_q      <= 1'b0;
         more_q    <= 1'b0;
         ten_sel_q <= 1'b0;
      end else begin
         hit_q <= 1'b0;
         gc_q  <= 1'b0;
         if (stop_det) begin
            state     <= ST_IDLE;
            ack_q     <= 1'b0;
            more_q    <= 1'b0;
            ten_sel_q <= 1'b0;
         end else if (start_det) begin
            state  <= ST_FIRST;
            ack_q  <= 1'b0;
            more_q <= 1'b0;
         end else if (state == ST_FIRST || state == ST_SECOND) begin
            if (byte_full) begin
               ack_q  <= j_ack;
               hit_q  <= j_ack;
               gc_q   <= j_ack & j_gc;
               more_q <= j_ack & j_more;
               if (j_ack)
                  rw_q <= j_rw;
               if (j_ack && state == ST_SECOND)
                  ten_sel_q <= 1'b1;
            end
            if (ack_end) begin
               ack_q <= 1'b0;
               state <= more_q ? ST_SECOND : ST_HOLD;
            end
         end
      end
   end

   assign ack_o   = ack_q;
   assign hit_o   = hit_q;
   assign gcall_o = gc_q;
   assign rw_o    = rw_q;

endmodule

// File: rtl/i2c_am_match_chk.sv
module i2c_am_match_chk (
   input logic clk,
   input logic rst_n,
   input logic scl_i,
   input logic sda_i,
   input logic cfg_gc_en,
   input logic ack_o,
   input logic hit_o,
   input logic gcall_o,
   input logic rw_o
);

   a_r2_ack_rise_with_hit: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ack_o) |-> hit_o);

   a_r2_hit_single: assert property (@(posedge clk) disable iff (!rst_n)
      hit_o |=> !hit_o);

   a_r3_gc_with_hit: assert property (@(posedge clk) disable iff (!rst_n)
      gcall_o |-> hit_o);

   a_r3_gc_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      gcall_o |-> cfg_gc_en);

   a_r7_rw_only_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(rw_o) |-> hit_o);

   a_r8_stop_drops_ack: assert property (@(posedge clk) disable iff (!rst_n)
      (scl_i && $past(scl_i) && sda_i && !$past(sda_i)) |=> !ack_o);

endmodule

bind i2c_addr_match i2c_am_match_chk u_chk (.*);

// File: tb/i2c_addr_match_tb_top.sv
module i2c_addr_match_tb_top;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic       rst_n = 1'b0;
   logic       scl = 1'b1, sda = 1'b1;
   logic [9:0] own = '0, mask = '0;
   logic       gc_en = 1'b0, ten = 1'b0;
   logic       ack, hit, gcall, rw;

   int   checks = 0, errors = 0, hit_cnt = 0;
   logic last_gc = 1'b0;
   bit   done = 1'b0;
   localparam int H = 3;

   i2c_addr_match dut_i (
      .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda),
      .cfg_own_addr(own), .cfg_mask(mask), .cfg_gc_en(gc_en),
      .cfg_ten_bit(ten), .ack_o(ack), .hit_o(hit), .gcall_o(gcall),
      .rw_o(rw)
   );

   always @(negedge clk) if (rst_n && hit) begin
      hit_cnt++;
      last_gc = gcall;
   end

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic hw();
      repeat (H) @(negedge clk);
   endtask

   task automatic bus_start();
      sda = 1'b1; hw(); scl = 1'b1; hw(); sda = 1'b0; hw(); scl = 1'b0; hw();
   endtask

   task automatic bus_stop();
      sda = 1'b0; hw(); scl = 1'b1; hw(); sda = 1'b1; hw();
   endtask

   task automatic send_bits(input logic [7:0] b, input int n);
      for (int i = 7; i > 7 - n; i--) begin
         sda = b[i]; hw(); scl = 1'b1; hw(); scl = 1'b0;
      end
   endtask

   task automatic send_byte(input logic [7:0] b, output logic got);
      send_bits(b, 8);
      sda = 1'b1; hw(); scl = 1'b1; hw();
      got = ack;
      hw(); scl = 1'b0; hw();
      chk("R9", "ack released after ninth clock", ack, 0);
   endtask

   function automatic logic exp7(input logic [6:0] a, input logic r,
                                 input logic [6:0] o, input logic [6:0] m,
                                 input logic g);
      if (a == 7'd0 && !r) return g;
      if (a[6:3] == 4'd0 || a[6:3] == 4'd15) return 1'b0;
      for (int i = 0; i < 7; i++)
         if (!m[i] && a[i] != o[i]) return 1'b0;
      return 1'b1;
   endfunction

   task automatic run7(input logic [6:0] o, input logic [6:0] m, input logic g);
      logic got, e;
      string req;
      int h0;
      own = {3'b0, o}; mask = {3'b0, m}; gc_en = g; ten = 1'b0;
      for (int a = 0; a < 128; a++) begin
         for (int r = 0; r < 2; r++) begin
            e = exp7(7'(a), 1'(r), o, m, g);
            if (a == 0 && r == 0) req = "R3";
            else if (a[6:3] == 4'd0 || a[6:3] == 4'd15) req = "R4";
            else req = "R2";
            h0 = hit_cnt;
            bus_start();
            send_byte({7'(a), 1'(r)}, got);
            chk(req, "ack 7-bit", got, e);
            chk(req, "hit pulses", hit_cnt - h0, e);
            if (e) begin
               chk("R7", "rw latched", rw, r);
               chk("R3", "gcall flag", last_gc, (a == 0 && r == 0));
            end
            bus_stop();
         end
      end
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual=1 expected=0");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic got, e;
      string req;
      int h0;
      repeat (4) @(negedge clk);
      chk("R1", "ack after reset", ack, 0);
      chk("R1", "hit after reset", hit, 0);
      chk("R1", "gcall after reset", gcall, 0);
      chk("R1", "rw after reset", rw, 0);
      rst_n = 1'b1;
      hw();

      run7(7'h55, 7'h00, 1'b1);
      run7(7'h00, 7'h20, 1'b0);
      run7(7'h3C, 7'h7F, 1'b1);

      // 10-bit first-byte sweep
      own = 10'h2A5; mask = 10'h00F; gc_en = 1'b1; ten = 1'b1;
      for (int v = 0; v < 256; v++) begin
         e = ((v[7:3] == 5'b11110) && (v[2:1] == 2'b10) && !v[0]) || (v == 0);
         if (v == 0) req = "R3";
         else if (v[7:3] == 5'b11110 && v[0]) req = "R6";
         else if (v[7:3] == 5'b11110) req = "R5";
         else req = "R4";
         bus_start();
         send_byte(8'(v), got);
         chk(req, "ack 10-bit first byte", got, e);
         bus_stop();
      end

      // 10-bit second-byte sweep
      for (int v = 0; v < 256; v++) begin
         e = ((8'(v) ^ 8'hA5) & 8'hF0) == 8'h00;
         bus_start();
         send_byte(8'hF4, got);
         chk("R5", "header ack", got, 1);
         send_byte(8'(v), got);
         chk("R5", "ack 10-bit second byte", got, e);
         if (e) chk("R7", "rw after second byte", rw, 0);
         bus_stop();
      end

      // repeated START read
      bus_start(); send_byte(8'hF4, got); send_byte(8'hA5, got);
      bus_start(); send_byte(8'hF5, got);
      chk("R6", "read header after restart", got, 1);
      chk("R7", "rw read", rw, 1);
      bus_stop();
      bus_start(); send_byte(8'hF5, got);
      chk("R6", "read header after STOP", got, 0);
      bus_stop();
      bus_start(); send_byte(8'hF4, got); send_byte(8'h05, got);
      chk("R5", "second byte mismatch", got, 0);
      bus_start(); send_byte(8'hF5, got);
      chk("R6", "read header without selection", got, 0);
      bus_stop();

      // header bits masked
      mask = 10'h30F;
      bus_start(); send_byte(8'hF0, got);
      chk("R5", "masked header bits", got, 1);
      bus_stop();

      // aborted bytes
      own = 10'h055; mask = 10'h000; ten = 1'b0;
      h0 = hit_cnt;
      bus_start(); send_bits(8'hAA, 4); bus_stop(); hw();
      chk("R8", "hit after STOP abort", hit_cnt - h0, 0);
      chk("R8", "ack after STOP abort", ack, 0);
      bus_start(); send_byte(8'hAA, got);
      chk("R8", "ack after abort", got, 1);
      bus_stop();
      h0 = hit_cnt;
      bus_start(); send_bits(8'hAA, 5); bus_start();
      chk("R8", "hit after mid-byte START", hit_cnt - h0, 0);
      send_byte(8'hAA, got);
      chk("R8", "ack after mid-byte START", got, 1);
      bus_stop();
      bus_start(); send_byte(8'hAC, got);
      chk("R9", "non-matching byte", got, 0);
      bus_stop();

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule